// File: doc/BRIEF.md
# Key-Sequence Access Gate

This block sits inside a flash controller and decides whether the protected information region (system and user areas) may be read or written. Software unlocks it by writing three fixed 32-bit words, one after another, to a single write-only key register. Only the correct words, in the correct order, open the gate. Once the gate is open, any later write to the key register closes it again. A read of the key register always returns zero, so the key words cannot be observed through it.

The block watches a simple bus port. `wr_en` together with `wr_data` is one write, and `rd_en` is one read. It drives a single registered enable, `access_en`, to the rest of the controller. Inside is a four-state machine:

- `ST_LOCKED`: no progress.
- `ST_STEP1`: the first word has been seen.
- `ST_STEP2`: the first two words have been seen.
- `ST_OPEN`: access is granted.

The state machine moves only on writes:

- **advance**: the expected word arrives, so the machine moves one step forward.
- **restart**: a wrong word that equals the first key moves the machine to `ST_STEP1`.
- **abort**: any other wrong word moves the machine to `ST_LOCKED`.
- **relock**: any write while in `ST_OPEN` moves the machine to `ST_LOCKED`.

With no write in a cycle, the machine holds its state.

Top module: `key_gate_seq`

## Requirements
- R1: Reset leaves `access_en` at 0 and the sequence progress at zero. The second and third keys written right after reset do not open the gate.
- R2: Writing 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 sets `access_en` to 1.
- R3: While `access_en` is 1, a write of any value, including the first key, clears `access_en` and sets the progress to zero.
- R4: `rd_data` is always all zeros, whatever the state and whether or not `rd_en` is high.
- R5: In `ST_STEP1` or `ST_STEP2`, a written word that is neither the expected key nor the first key returns the progress to zero.
- R6: A wrong word equal to the first key (0x3A7F5CA3) sets the progress to step one, so the second and third keys that follow open the gate.
- R7: Reads and idle cycles between key writes leave the progress and `access_en` unchanged.
- R8: `access_en` is registered. During the cycle in which the final key is written it still shows the old value. It changes on that cycle's rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the key register |
| rd_en | input | 1 | Read strobe for the key register |
| wr_data | input | 32 | Word being written |
| rd_data | output | 32 | Read data, always zero |
| access_en | output | 1 | Access enable for the information region |

## Verification
The assertions take for granted that a write is fully described by `wr_en` and `wr_data` in a single cycle, that both are settled at the rising edge, and that reset is applied asynchronously before any traffic. The bench drives inputs only on the falling edge and holds them for one full cycle, so every write is seen exactly once. The random stimulus mixes the three key words heavily with arbitrary words, reads and idle cycles. This reaches the advance, restart, abort and relock transitions from every state, while the bus stays within the single-cycle write contract.

// File: rtl/key_gate_pkg.sv
package key_gate_pkg;

    localparam int unsigned KEY_W    = 32;
    localparam int unsigned KEY_CNT  = 3;

    localparam logic [KEY_W-1:0] KEY_FIRST  = 32'h3A7F_5CA3;
    localparam logic [KEY_W-1:0] KEY_SECOND = 32'hA1E3_4F20;
    localparam logic [KEY_W-1:0] KEY_THIRD  = 32'h9608_B2C1;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_STEP1  = 2'd1,
        ST_STEP2  = 2'd2,
        ST_OPEN   = 2'd3
    } gate_state_t;

endpackage

// File: rtl/key_gate_match.sv
module key_gate_match #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned NUM_KEYS = 3,
    parameter logic [NUM_KEYS*WORD_W-1:0] KEYS = '0
) (
    input  logic [WORD_W-1:0]   word,
    output logic [NUM_KEYS-1:0] hit
);

    // One equality comparator per key; key i sits in slice i of KEYS.
    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_cmp
        assign hit[i] = (word == KEYS[i*WORD_W +: WORD_W]);
    end

endmodule

// File: rtl/key_gate_fsm.sv
module key_gate_fsm
    import key_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  hit,
    output gate_state_t state,
    output logic        access_en
);

    gate_state_t state_nx;

    // Next-state logic: only writes move the machine.
    always_comb begin
        state_nx = state;
        if (wr_en) begin
            unique case (state)
                ST_LOCKED: state_nx = hit[0] ? ST_STEP1 : ST_LOCKED;
                ST_STEP1:  state_nx = hit[1] ? ST_STEP2 :
                                      (hit[0] ? ST_STEP1 : ST_LOCKED);
                ST_STEP2:  state_nx = hit[2] ? ST_OPEN :
                                      (hit[0] ? ST_STEP1 : ST_LOCKED);
                ST_OPEN:   state_nx = ST_LOCKED;   // relock on any write
                default:   state_nx = ST_LOCKED;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    // Output register: enable follows the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) access_en <= 1'b0;
        else        access_en <= (state_nx == ST_OPEN);
    end

endmodule

// File: rtl/key_gate_seq.sv
module key_gate_seq
    import key_gate_pkg::*;
#(
    parameter int unsigned      WORD_W = KEY_W,
    parameter logic [WORD_W-1:0] KEY_1 = KEY_FIRST,
    parameter logic [WORD_W-1:0] KEY_2 = KEY_SECOND,
    parameter logic [WORD_W-1:0] KEY_3 = KEY_THIRD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              access_en
);

    localparam logic [KEY_CNT*WORD_W-1:0] KEY_VEC = {KEY_3, KEY_2, KEY_1};

    logic [KEY_CNT-1:0] hit;
    gate_state_t        state;

    key_gate_match #(
        .WORD_W  (WORD_W),
        .NUM_KEYS(KEY_CNT),
        .KEYS    (KEY_VEC)
    ) u_match (
        .word(wr_data),
        .hit (hit)
    );

    key_gate_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .hit      (hit),
        .state    (state),
        .access_en(access_en)
    );

    // Key register is write-only: a read returns zero and never reaches the FSM.
    assign rd_data = {WORD_W{1'b0}} & {WORD_W{rd_en}};

endmodule

// File: rtl/key_gate_chk.sv
module key_gate_chk #(
    parameter int unsigned       WORD_W = 32,
    parameter logic [WORD_W-1:0] KEY_1  = '0,
    parameter logic [WORD_W-1:0] KEY_3  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic              access_en
);

    // R1: held in reset means locked
    always_comb begin
        if (!rst_n) begin
            p_reset_locked_r1: assert (!access_en);
        end
    end

    // R2 / R8: the enable only rises on the edge that captures the third key
    p_open_after_key3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_en) |-> $past(wr_en && (wr_data == KEY_3)));

    // R3: any write while open closes the gate
    p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && wr_en) |=> !access_en);

    // R5: a word that is neither the first nor the last key cannot open the gate
    p_wrong_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data != KEY_3) && (wr_data != KEY_1)) |=> !access_en);

    // R7: without a write the enable does not move
    p_hold_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(access_en));

endmodule

bind key_gate_seq key_gate_chk #(
    .WORD_W(WORD_W),
    .KEY_1 (KEY_1),
    .KEY_3 (KEY_3)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .access_en(access_en)
);

// File: tb/tb_key_gate_seq.sv
`timescale 1ns/1ps
module tb_key_gate_seq;

    localparam logic [31:0] K1 = 32'h3A7F_5CA3;
    localparam logic [31:0] K2 = 32'hA1E3_4F20;
    localparam logic [31:0] K3 = 32'h9608_B2C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        access_en;

    int checks = 0;
    int fails  = 0;
    int prog   = 0;   // model progress 0..3, 3 = open

    always #10 clk = ~clk;   // 50 MHz

    key_gate_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .access_en(access_en)
    );

    function automatic int next_prog(input int p, input logic [31:0] w);
        if (p == 3) return 0;
        if (p == 0) return (w == K1) ? 1 : 0;
        if (p == 1) return (w == K2) ? 2 : ((w == K1) ? 1 : 0);
        return (w == K3) ? 3 : ((w == K1) ? 1 : 0);
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive on the falling edge, check before and after the rising edge.
    task automatic apply(input logic we, input logic re, input logic [31:0] d,
                         input string tag);
        @(negedge clk);
        wr_en = we; rd_en = re; wr_data = d;
        #1;
        check(access_en == (prog == 3), "R8 pre-edge", {31'd0, access_en}, {31'd0, prog == 3});
        check(rd_data == 32'd0, "R4 read zero", rd_data, 32'd0);
        @(posedge clk);
        #1;
        if (we) prog = next_prog(prog, d);
        check(access_en == (prog == 3), tag, {31'd0, access_en}, {31'd0, prog == 3});
    endtask

    task automatic expect_open(input logic exp, input string tag);
        check(access_en == exp, tag, {31'd0, access_en}, {31'd0, exp});
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #35;
        check(access_en == 1'b0, "R1 reset enable", {31'd0, access_en}, 32'd0);
        check(rd_data == 32'd0, "R4 reset read", rd_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: progress starts at zero
        apply(1, 0, K2, "R1 k2 after reset");
        apply(1, 0, K3, "R1 k3 after reset");
        expect_open(0, "R1 still locked");

        // R2: correct order opens
        apply(1, 0, K1, "R2 first");
        apply(1, 0, K2, "R2 second");
        apply(1, 0, K3, "R2 third");
        expect_open(1, "R2 open");

        // R4 / R7: reads while open
        apply(0, 1, 32'hFFFF_FFFF, "R7 read while open");
        apply(0, 0, 32'h0, "R7 idle while open");
        expect_open(1, "R7 still open");

        // R3: write of first key relocks to zero progress
        apply(1, 0, K1, "R3 relock");
        expect_open(0, "R3 closed");
        apply(1, 0, K2, "R3 k2 after relock");
        apply(1, 0, K3, "R3 k3 after relock");
        expect_open(0, "R3 progress zero");

        // R5: abort on a bad word
        apply(1, 0, K1, "R5 first");
        apply(1, 0, K2, "R5 second");
        apply(1, 0, 32'h1234_5678, "R5 bad word");
        apply(1, 0, K3, "R5 third after abort");
        expect_open(0, "R5 locked");

        // R6: first key as wrong word restarts at step one
        apply(1, 0, K1, "R6 first");
        apply(1, 0, K1, "R6 repeat first");
        apply(1, 0, K2, "R6 second");
        apply(1, 0, K1, "R6 first instead of third");
        apply(1, 0, K2, "R6 second again");
        apply(1, 0, K3, "R6 third");
        expect_open(1, "R6 open");
        apply(1, 0, 32'h0, "R3 zero write relocks");

        // R7: reads and gaps between writes
        apply(1, 0, K1, "R7 first");
        apply(0, 1, 32'h0, "R7 read gap");
        apply(0, 0, 32'h0, "R7 idle gap");
        apply(1, 0, K2, "R7 second");
        apply(0, 1, K3, "R7 read with key on bus");
        apply(1, 0, K3, "R7 third");
        expect_open(1, "R7 open");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d;
            logic we, re;
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1, 2: d = K1;
                3, 4:    d = K2;
                5, 6:    d = K3;
                default: d = $urandom();
            endcase
            we = ($urandom_range(0, 3) != 0);
            re = ($urandom_range(0, 2) == 0);
            apply(we, re, d, "R2/R3/R5/R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule